// File: doc/BRIEF.md
# Lockable GPIO Control Register Bank

This block is the software-facing register file of a general-purpose I/O controller for up to 32 pins. A simple memory-mapped bus writes and reads 32-bit words at byte offsets. The block keeps every per-pin setting: drive value, driver enable, open-drain selection, inversion, pull-up, pull-down, input gating, event mode, both-edge event selection and event interrupt mask. It presents these settings continuously to the pin resolver and the event logic that sit beside it. Reads of the input word and the event status are passed straight through from those neighbours. A write to the event-status offset is turned into a one-cycle write-one-to-clear strobe toward the event logic.

Three settings have additional set and clear alias offsets, so that software can change single bits without a read-modify-write: the drive value, the driver enable and the event mask. A temporary lock protects the whole configuration. Any write to either of the two lock offsets engages it. While it is engaged, configuration writes are dropped. Only two key words, written to the two lock offsets in a fixed order, release it. The bus reset input is asynchronous and active low, and its release is synchronised inside the block, which delays it by two clock edges.

Top module: `gpio_lockbank`

## Requirements
- R1: After reset every configuration register reads zero, the lock offset 0x00 reads 0 (unlocked), and every configuration output is zero.
- R2: While unlocked, a write to a plain offset replaces that register with the low NPINS data bits. The register reads back and shows on its output port from the next cycle. The plain offsets are 0x08 inversion, 0x0C drive value, 0x10 driver enable, 0x14 open-drain select, 0x1C pull-up, 0x20 pull-down, 0x28 event mode, 0x2C both-edge select, 0x40 event mask and 0x58 input gating.
- R3: While unlocked, a write to a set alias ORs the data into its register, and a write to a clear alias clears the bits that are 1 in the data. The set/clear pairs are drive value 0x68/0x6C, driver enable 0x70/0x74 and event mask 0x44/0x48. All other bits stay unchanged.
- R4: While unlocked, a write of any value to offset 0x00 or 0x7C engages the lock. Offset 0x00 then reads 1.
- R5: While locked, writes to any plain offset or any set/clear alias leave every register and output unchanged.
- R6: While locked, writing 0xC0DE1248 to 0x7C and then 0xC0DEFA73 to 0x00 releases the lock. Non-lock writes in between do not disturb the sequence.
- R7: While locked, a wrong key value, or a lock-offset write out of order, leaves the bank locked. It restarts the sequence, so a following second key alone does not unlock. Writing the first key again restarts at step two.
- R8: A write to 0x4C, locked or not, raises evst_clr_en for exactly the next cycle, with evst_clr_bits equal to the written data. Other writes leave the strobe low.
- R9: Offset 0x04 reads pin_din and offset 0x4C reads evt_stat. Offset 0x7C, the alias offsets and every unmapped offset read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 7 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 7 | Read byte offset |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| pin_din | input | NPINS | Resolved input word from the pin resolver |
| evt_stat | input | NPINS | Event status from the event logic |
| evst_clr_en | output | 1 | One-cycle event-status clear strobe |
| evst_clr_bits | output | NPINS | Bits to clear with the strobe |
| out_dout | output | NPINS | Drive value |
| out_oe | output | NPINS | Driver enable |
| out_otyp | output | NPINS | Open-drain select |
| out_pol | output | NPINS | Inversion |
| out_pu | output | NPINS | Pull-up |
| out_pd | output | NPINS | Pull-down |
| out_iem | output | NPINS | Input gating |
| out_evtyp | output | NPINS | Event mode (edge when 1) |
| out_evbe | output | NPINS | Both-edge select |
| out_even | output | NPINS | Event mask |
| lock_state | output | 1 | High while the bank is locked |

## Verification
A wrong lock state shows at once on offset 0x00 and on lock_state. It also shows one cycle after the next configuration write, which either sticks when it should have been dropped or is dropped when it should have stuck. A corrupt key-sequence step stays hidden until the next lock-offset write. For that reason the bench issues wrong keys, out-of-order keys, repeated first keys and interleaved ordinary writes, and after each one it checks lock_state. A faulty set or clear merge shows on the affected output port in the cycle after the write, and the bench compares every exported register after every operation.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 7;
  localparam int NCFG   = 10;

  localparam logic [ADDR_W-1:0] A_LOCK_A = 7'h00;
  localparam logic [ADDR_W-1:0] A_PIN_IN = 7'h04;
  localparam logic [ADDR_W-1:0] A_EVSTAT = 7'h4C;
  localparam logic [ADDR_W-1:0] A_LOCK_B = 7'h7C;

  localparam logic [BUS_W-1:0] KEY_FIRST  = 32'hC0DE_1248;
  localparam logic [BUS_W-1:0] KEY_SECOND = 32'hC0DE_FA73;

  // configuration register slots
  localparam int C_POL = 0, C_DOUT = 1, C_OE = 2, C_OTYP = 3, C_PU = 4;
  localparam int C_PD = 5, C_EVTYP = 6, C_EVBE = 7, C_EVEN = 8, C_IEM = 9;

  typedef enum logic [1:0] {LK_OPEN, LK_SHUT, LK_HALF} lock_st_t;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int i);
    case (i)
      C_POL:   return 7'h08;
      C_DOUT:  return 7'h0C;
      C_OE:    return 7'h10;
      C_OTYP:  return 7'h14;
      C_PU:    return 7'h1C;
      C_PD:    return 7'h20;
      C_EVTYP: return 7'h28;
      C_EVBE:  return 7'h2C;
      C_EVEN:  return 7'h40;
      default: return 7'h58;
    endcase
  endfunction

  function automatic bit cfg_has_alias(input int i);
    return (i == C_DOUT) || (i == C_OE) || (i == C_EVEN);
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_set_addr(input int i);
    case (i)
      C_DOUT:  return 7'h68;
      C_OE:    return 7'h70;
      default: return 7'h44;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_clr_addr(input int i);
    return cfg_set_addr(i) + 7'h04;
  endfunction
endpackage

// File: rtl/gpio_lockbank_reg.sv
module gpio_lockbank_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_full,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = wr_full | wr_set | wr_clr;
    q_d  = q;
    if (wr_full)     q_d = wdata;
    else if (wr_set) q_d = q | wdata;
    else if (wr_clr) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/gpio_lockbank_lock.sv
module gpio_lockbank_lock
  import gpio_lockbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [BUS_W-1:0] wdata,
  output logic             locked
);
  lock_st_t st_q, st_d;
  logic     st_en;

  always_comb begin
    st_en = wr_en & (hit_a | hit_b);
    st_d  = st_q;
    if (st_q == LK_OPEN) begin
      st_d = LK_SHUT;
    end else if (hit_b) begin
      st_d = (wdata == KEY_FIRST) ? LK_HALF : LK_SHUT;
    end else begin
      st_d = (st_q == LK_HALF && wdata == KEY_SECOND) ? LK_OPEN : LK_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= LK_OPEN;
    else if (st_en) st_q <= st_d;
  end

  assign locked = (st_q != LK_OPEN);
endmodule

// File: rtl/gpio_lockbank.sv
module gpio_lockbank
  import gpio_lockbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [6:0]        bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [6:0]        bus_raddr,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_din,
  input  logic [NPINS-1:0]  evt_stat,
  output logic              evst_clr_en,
  output logic [NPINS-1:0]  evst_clr_bits,
  output logic [NPINS-1:0]  out_dout,
  output logic [NPINS-1:0]  out_oe,
  output logic [NPINS-1:0]  out_otyp,
  output logic [NPINS-1:0]  out_pol,
  output logic [NPINS-1:0]  out_pu,
  output logic [NPINS-1:0]  out_pd,
  output logic [NPINS-1:0]  out_iem,
  output logic [NPINS-1:0]  out_evtyp,
  output logic [NPINS-1:0]  out_evbe,
  output logic [NPINS-1:0]  out_even,
  output logic              lock_state
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic locked;
  logic wr_open;
  logic [NPINS-1:0] cfg_q [NCFG];

  gpio_lockbank_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (bus_we),
    .hit_a  (bus_waddr == A_LOCK_A),
    .hit_b  (bus_waddr == A_LOCK_B),
    .wdata  (bus_wdata),
    .locked (locked)
  );

  assign wr_open = bus_we & ~locked;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic full_w, set_w, clr_w;
    assign full_w = wr_open && (bus_waddr == cfg_addr(g));
    if (cfg_has_alias(g)) begin : g_alias
      assign set_w = wr_open && (bus_waddr == cfg_set_addr(g));
      assign clr_w = wr_open && (bus_waddr == cfg_clr_addr(g));
    end else begin : g_plain
      assign set_w = 1'b0;
      assign clr_w = 1'b0;
    end
    gpio_lockbank_reg #(.W(NPINS)) u_reg (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .wr_full (full_w),
      .wr_set  (set_w),
      .wr_clr  (clr_w),
      .wdata   (bus_wdata[NPINS-1:0]),
      .q       (cfg_q[g])
    );
  end

  // event-status clear strobe, allowed while locked
  logic             evc_en_d;
  logic [NPINS-1:0] evc_bits_d;

  always_comb begin
    evc_en_d   = bus_we && (bus_waddr == A_EVSTAT);
    evc_bits_d = evc_en_d ? bus_wdata[NPINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      evst_clr_en   <= 1'b0;
      evst_clr_bits <= '0;
    end else begin
      evst_clr_en   <= evc_en_d;
      evst_clr_bits <= evc_bits_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_raddr == A_LOCK_A) bus_rdata = {31'b0, locked};
    if (bus_raddr == A_PIN_IN) bus_rdata = 32'(pin_din);
    if (bus_raddr == A_EVSTAT) bus_rdata = 32'(evt_stat);
    for (int i = 0; i < NCFG; i++) begin
      if (bus_raddr == cfg_addr(i)) bus_rdata = 32'(cfg_q[i]);
    end
  end

  assign out_pol    = cfg_q[C_POL];
  assign out_dout   = cfg_q[C_DOUT];
  assign out_oe     = cfg_q[C_OE];
  assign out_otyp   = cfg_q[C_OTYP];
  assign out_pu     = cfg_q[C_PU];
  assign out_pd     = cfg_q[C_PD];
  assign out_evtyp  = cfg_q[C_EVTYP];
  assign out_evbe   = cfg_q[C_EVBE];
  assign out_even   = cfg_q[C_EVEN];
  assign out_iem    = cfg_q[C_IEM];
  assign lock_state = locked;
endmodule

// File: rtl/gpio_lockbank_chk.sv
module gpio_lockbank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [6:0]       bus_waddr,
  input logic [31:0]      bus_wdata,
  input logic             lock_state,
  input logic [NPINS-1:0] out_dout,
  input logic [NPINS-1:0] out_oe,
  input logic             evst_clr_en
);
  AST_LOCK_ENGAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_state && bus_we && (bus_waddr == 7'h00 || bus_waddr == 7'h7C)) |=> lock_state); // R4

  AST_LOCK_FREEZES_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state |=> $stable(out_dout)); // R5

  AST_LOCK_FREEZES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state |=> $stable(out_oe)); // R5

  AST_RELEASE_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_state) |-> $past(bus_we && bus_waddr == 7'h00 && bus_wdata == 32'hC0DE_FA73)); // R6

  AST_OE_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_state && bus_we && bus_waddr == 7'h70)
      |=> ((out_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R3

  AST_EVST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_waddr == 7'h4C) |=> evst_clr_en); // R8
endmodule

bind gpio_lockbank gpio_lockbank_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .bus_we      (bus_we),
  .bus_waddr   (bus_waddr),
  .bus_wdata   (bus_wdata),
  .lock_state  (lock_state),
  .out_dout    (out_dout),
  .out_oe      (out_oe),
  .evst_clr_en (evst_clr_en)
);

// File: tb/gpio_lockbank_bench.sv
module gpio_lockbank_bench;
  localparam logic [31:0] K1 = 32'hC0DE_1248;
  localparam logic [31:0] K2 = 32'hC0DE_FA73;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_waddr, bus_raddr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_din, evt_stat;
  logic        evst_clr_en;
  logic [31:0] evst_clr_bits;
  logic [31:0] o_dout, o_oe, o_otyp, o_pol, o_pu, o_pd, o_iem, o_evtyp, o_evbe, o_even;
  logic        lock_state;

  always #10 clk = ~clk;

  gpio_lockbank u_gpio_lockbank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .pin_din(pin_din), .evt_stat(evt_stat), .evst_clr_en(evst_clr_en),
    .evst_clr_bits(evst_clr_bits), .out_dout(o_dout), .out_oe(o_oe),
    .out_otyp(o_otyp), .out_pol(o_pol), .out_pu(o_pu), .out_pd(o_pd),
    .out_iem(o_iem), .out_evtyp(o_evtyp), .out_evbe(o_evbe), .out_even(o_even),
    .lock_state(lock_state)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // model: 0 open, 1 shut, 2 first key seen
  logic [31:0] m_reg [10];
  int          m_lock;

  function automatic logic [6:0] b_addr(input int i);
    case (i)
      0: return 7'h0C; 1: return 7'h10; 2: return 7'h14; 3: return 7'h08;
      4: return 7'h1C; 5: return 7'h20; 6: return 7'h58; 7: return 7'h28;
      8: return 7'h2C; default: return 7'h40;
    endcase
  endfunction

  function automatic logic [31:0] b_out(input int i);
    case (i)
      0: return o_dout;  1: return o_oe;    2: return o_otyp; 3: return o_pol;
      4: return o_pu;    5: return o_pd;    6: return o_iem;  7: return o_evtyp;
      8: return o_evbe;  default: return o_even;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    if (a == 7'h00) return {31'b0, m_lock != 0};
    if (a == 7'h04) return pin_din;
    if (a == 7'h4C) return evt_stat;
    for (int i = 0; i < 10; i++) if (a == b_addr(i)) return m_reg[i];
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [6:0] a, input logic [31:0] d);
    if (a == 7'h00) begin
      m_lock = (m_lock == 0) ? 1 : ((m_lock == 2 && d == K2) ? 0 : 1);
    end else if (a == 7'h7C) begin
      m_lock = (m_lock == 0) ? 1 : ((d == K1) ? 2 : 1);
    end else if (m_lock == 0) begin
      for (int i = 0; i < 10; i++) if (a == b_addr(i)) m_reg[i] = d;
      case (a)
        7'h68: m_reg[0] |= d;   7'h6C: m_reg[0] &= ~d;
        7'h70: m_reg[1] |= d;   7'h74: m_reg[1] &= ~d;
        7'h44: m_reg[9] |= d;   7'h48: m_reg[9] &= ~d;
        default: ;
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    bus_raddr = a;
    #1;
    check(tag, bus_rdata, exp_read(a));
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    model_write(a, d);
    @(negedge clk);
    bus_we = 1'b0;
    // R8: strobe visible in the cycle after the write edge
    check("R8 strobe", {31'b0, evst_clr_en}, {31'b0, a == 7'h4C});
    if (a == 7'h4C) check("R8 bits", evst_clr_bits, d);
    check("R4/R6/R7 lock_state", {31'b0, lock_state}, {31'b0, m_lock != 0});
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 10; i++) begin
      rd(b_addr(i), tag);
      check(tag, b_out(i), m_reg[i]);
    end
    rd(7'h00, tag);
  endtask

  initial begin
    logic [6:0] pool [24];
    pool = '{7'h08, 7'h0C, 7'h10, 7'h14, 7'h1C, 7'h20, 7'h28, 7'h2C, 7'h40, 7'h44,
             7'h48, 7'h4C, 7'h58, 7'h68, 7'h6C, 7'h70, 7'h74, 7'h04, 7'h18, 7'h30,
             7'h50, 7'h60, 7'h78, 7'h24};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0; bus_raddr = '0;
    pin_din = 32'h1357_9BDF; evt_stat = 32'h0246_8ACE;
    for (int i = 0; i < 10; i++) m_reg[i] = '0;
    m_lock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check_all("R1 reset");
    check("R1 lock_state", {31'b0, lock_state}, 32'h0);
    rd(7'h04, "R9 din"); rd(7'h4C, "R9 evst");
    rd(7'h7C, "R9 lock2 reads zero"); rd(7'h68, "R9 alias reads zero");
    rd(7'h30, "R9 unmapped");

    // R2 plain writes
    for (int i = 0; i < 10; i++) wr(b_addr(i), 32'hA5A5_0000 ^ (i * 32'h1111));
    check_all("R2 plain");
    // R3 aliases
    wr(7'h10, 32'h3456_789A); wr(7'h74, 32'h0003_0002); check("R3 oe clr", o_oe, 32'h3454_7898);
    wr(7'h70, 32'h0000_F001); check("R3 oe set", o_oe, 32'h3454_F899);
    wr(7'h68, 32'h0000_00FF); wr(7'h6C, 32'hA500_0000); wr(7'h44, 32'h8000_0001);
    wr(7'h48, 32'h0000_0001);
    check_all("R3 alias");
    // R4 lock via second lock offset, R5 frozen
    wr(7'h7C, 32'h0); rd(7'h00, "R4 locked");
    wr(7'h0C, 32'hFFFF_FFFF); wr(7'h70, 32'hFFFF_FFFF); wr(7'h48, 32'hFFFF_FFFF);
    wr(7'h4C, 32'h0000_00F0);
    check_all("R5 locked writes");
    // R7 wrong orders
    wr(7'h00, K2); rd(7'h00, "R7 second key first");
    wr(7'h7C, K1); wr(7'h00, 32'h1234_5678); wr(7'h00, K2); rd(7'h00, "R7 bad key restarts");
    wr(7'h7C, 32'h5); wr(7'h00, K2); rd(7'h00, "R7 bad first key");
    wr(7'h7C, K1); wr(7'h7C, K1); wr(7'h10, 32'h0); wr(7'h00, K2); rd(7'h00, "R6 unlock");
    wr(7'h10, 32'h0000_FFFF); check("R6 writes resume", o_oe, 32'h0000_FFFF);
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00, "R4 lock via first offset");
    wr(7'h7C, K1); wr(7'h00, K2); rd(7'h00, "R6 unlock again");

    // random phase
    for (int it = 0; it < 4000; it++) begin
      int r;
      r = int'($urandom % 100);
      pin_din = $urandom; evt_stat = $urandom;
      if (r < 4) wr((($urandom % 2) == 0) ? 7'h00 : 7'h7C, $urandom);
      else if (r < 9) begin wr(7'h7C, K1); wr(7'h00, K2); end
      else if (r < 12) wr(7'h7C, K1);
      else if (r < 15) wr(7'h00, K2);
      else wr(pool[$urandom % 24], $urandom);
      rd(pool[$urandom % 24], "R2/R3/R5/R9 random read");
      if (it % 50 == 0) check_all("R2/R3/R5 random sweep");
    end
    check_all("final");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule